// File: doc/BRIEF.md
# Digital Delta-Sigma Modulator Loop

This block turns a stream of signed fixed-point samples into a one-bit stream whose time average follows the input. On every clock cycle where the sample strobe is high, it subtracts the fed-back output level from the input, accumulates the difference, and compares the final accumulator with zero. A one on the output stands for +1.0 full scale and a zero for -1.0 full scale. A parameter selects first-order shaping, with noise transfer 1 - z^-1, or second-order shaping, with noise transfer (1 - z^-1)^2. Both orders give a signal transfer of one sample delay.

The input word is 16 bits wide with 14 fraction bits, so full scale (1.0) is 16384. The accumulators carry three guard bits above the input width (19 bits by default). They clip at their limits and never wrap around. A load strobe presets the output-side accumulator to a chosen value, which makes start-up sequences repeatable. A debug port shows that accumulator at all times. The output bit is the sign of the debug value, so it changes right after the clock edge on which the accumulator is updated.

Top module: `dsm_modulator`

## Requirements
- R1: While reset is active, and after it is released with no other stimulus, every accumulator reads zero, `acc_o` is 0 and `bit_o` is 1.
- R2: The quantizer threshold is at zero. `bit_o` is 1 (level +16384) when `acc_o` is zero or positive, and 0 (level -16384) when `acc_o` is negative.
- R3: In first order, each strobed cycle sets the accumulator to acc + din - level, where level comes from `bit_o` before the edge. A new input therefore reaches `bit_o` only after the following edge.
- R4: When `load_i` is high, the output-side accumulator takes `preset_i` and the second-order inner accumulator takes zero. This happens on the next edge, and `load_i` wins over `en_i`.
- R5: With `en_i` and `load_i` both low, neither the accumulators nor `bit_o` change, whatever `din_i` does.
- R6: In first order, a preset of 1638 (about 0.1) followed by a constant input of 5461 (about 1/3) gives `acc_o` values 1638, -9285, 12560, 1637. The matching bits are 1, 0, 1, 1.
- R7: In second order, each strobed cycle first sets v' = v + din - level and then sets w' = w + v' - level. `acc_o` is w, and level comes from the sign of w before the edge.
- R8: Every accumulator update is clipped to the range -262144 to 262143 and does not wrap.
- R9: With a constant input u held for N strobes, the number of ones minus the number of zeros stays within 4 (first order) or 8 (second order) of N*u/16384.
- R10: `acc_o` always shows the output-side accumulator, the one the quantizer reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_i | input | 1 | Sample strobe; the loop advances only on cycles where it is high |
| load_i | input | 1 | Presets the accumulators; takes priority over the strobe |
| preset_i | input | ACC_W | Signed value loaded into the output-side accumulator |
| din_i | input | IN_W | Signed input sample with FRAC_W fraction bits |
| bit_o | output | 1 | One-bit output: 1 means +1.0, 0 means -1.0 |
| acc_o | output | ACC_W | Debug view of the output-side accumulator |

## Verification
The three-sample start-up sequence is checked value by value. A design that used the current output level instead of the previous one, or that delayed the input by an extra register, would leave that sequence after the first step. Preset values at both accumulator limits are driven with the largest input of the matching sign. A wrapping adder would flip the sign and the output bit at that point, where a correct design holds the limit. Idle cycles with a changing input catch an update that ignores the strobe. A pseudo-random input stream with gaps in the strobe is compared against a model of the difference equations for both orders; this exposes a second stage wired to the wrong intermediate value. Long constant-input runs check that the output density matches the input, which fails for a feedback sign error or a wrong feedback level.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  // Noise-shaping order selectable at elaboration
  typedef enum int {
    ORD_FIRST  = 1,
    ORD_SECOND = 2
  } dsm_order_e;
endpackage

// File: rtl/dsm_rst_sync.sv
module dsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/dsm_accum.sv
module dsm_accum #(
  parameter int W  = 19,
  parameter int DW = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 load_i,
  input  logic signed [W-1:0]  load_val_i,
  input  logic signed [DW-1:0] delta_i,
  output logic signed [W-1:0]  acc_q_o,
  output logic signed [W-1:0]  acc_d_o
);
  localparam int SW = ((DW > W) ? DW : W) + 1;
  localparam logic signed [SW-1:0] MAX_S = SW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [SW-1:0] MIN_S = -(SW'(64'sd1 <<< (W-1)));

  logic signed [W-1:0]  acc_q;
  logic signed [W-1:0]  acc_d;
  logic signed [SW-1:0] sum;
  logic signed [W-1:0]  sum_sat;

  always_comb begin
    sum = SW'(acc_q) + SW'(delta_i);
    if (sum > MAX_S)      sum_sat = MAX_S[W-1:0];
    else if (sum < MIN_S) sum_sat = MIN_S[W-1:0];
    else                  sum_sat = sum[W-1:0];

    if (load_i)    acc_d = load_val_i;
    else if (en_i) acc_d = sum_sat;
    else           acc_d = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_q_o = acc_q;
  assign acc_d_o = acc_d;
endmodule

// File: rtl/dsm_modulator.sv
module dsm_modulator
  import dsm_pkg::*;
#(
  parameter dsm_order_e ORDER  = ORD_FIRST,
  parameter int         IN_W   = 16,
  parameter int         FRAC_W = 14,
  parameter int         GUARD  = 3,
  localparam int        ACC_W  = IN_W + GUARD
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    load_i,
  input  logic signed [ACC_W-1:0] preset_i,
  input  logic signed [IN_W-1:0]  din_i,
  output logic                    bit_o,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int DW = ACC_W + 1;
  localparam logic signed [DW-1:0] FS = DW'(64'sd1 <<< FRAC_W);

  logic                    rst_sync_n;
  logic signed [ACC_W-1:0] w_q;
  logic signed [DW-1:0]    level;
  logic signed [DW-1:0]    din_ext;

  dsm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  // Quantizer: threshold at zero on the output-side accumulator
  always_comb begin
    level   = w_q[ACC_W-1] ? -FS : FS;
    din_ext = DW'(din_i);
  end

  if (ORDER == ORD_FIRST) begin : g_first
    logic signed [ACC_W-1:0] w_d;
    logic signed [DW-1:0]    delta_w;

    always_comb delta_w = din_ext - level;

    dsm_accum #(.W(ACC_W), .DW(DW)) u_acc_w (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .en_i       (en_i),
      .load_i     (load_i),
      .load_val_i (preset_i),
      .delta_i    (delta_w),
      .acc_q_o    (w_q),
      .acc_d_o    (w_d)
    );
  end else begin : g_second
    logic signed [ACC_W-1:0] v_q;
    logic signed [ACC_W-1:0] v_d;
    logic signed [ACC_W-1:0] w_d;
    logic signed [DW-1:0]    delta_v;
    logic signed [DW-1:0]    delta_w;

    always_comb begin
      delta_v = din_ext - level;
      delta_w = DW'(v_d) - level;
    end

    dsm_accum #(.W(ACC_W), .DW(DW)) u_acc_v (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .en_i       (en_i),
      .load_i     (load_i),
      .load_val_i ('0),
      .delta_i    (delta_v),
      .acc_q_o    (v_q),
      .acc_d_o    (v_d)
    );

    dsm_accum #(.W(ACC_W), .DW(DW)) u_acc_w (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .en_i       (en_i),
      .load_i     (load_i),
      .load_val_i (preset_i),
      .delta_i    (delta_w),
      .acc_q_o    (w_q),
      .acc_d_o    (w_d)
    );
  end

  assign bit_o = ~w_q[ACC_W-1];
  assign acc_o = w_q;
endmodule

// File: rtl/dsm_modulator_chk.sv
module dsm_modulator_chk #(
  parameter int ORDER_N = 1,
  parameter int IN_W    = 16,
  parameter int FRAC_W  = 14,
  parameter int ACC_W   = 19
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    load,
  input logic signed [ACC_W-1:0] preset,
  input logic signed [IN_W-1:0]  din,
  input logic                    bit_o,
  input logic signed [ACC_W-1:0] acc
);
  localparam int FS = 1 << FRAC_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (acc == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(acc) && $stable(bit_o)));

  // R4
  preset_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc == $past(preset)));

  // R2
  preset_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bit_o == ($past(preset) >= 0)));

  if (ORDER_N == 1) begin : g_o1
    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load && bit_o && (int'(din) < FS)) |=> (acc < $past(acc)));
    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load && !bit_o && (int'(din) > -FS)) |=> (acc > $past(acc)));
  end
endmodule

bind dsm_modulator dsm_modulator_chk #(
  .ORDER_N (int'(ORDER)),
  .IN_W    (IN_W),
  .FRAC_W  (FRAC_W),
  .ACC_W   (ACC_W)
) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_sync_n),
  .en     (en_i),
  .load   (load_i),
  .preset (preset_i),
  .din    (din_i),
  .bit_o  (bit_o),
  .acc    (acc_o)
);

// File: tb/test_dsm_modulator.sv
module test_dsm_modulator;
  import dsm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int FS    = 16384;
  localparam int A_MAX = 262143;
  localparam int A_MIN = -262144;

  logic clk;
  logic rst_n;
  logic en;
  logic load;
  logic signed [18:0] preset;
  logic signed [15:0] din;
  logic bit1, bit2;
  logic signed [18:0] acc1, acc2;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  int m1_w, m2_v, m2_w;

  dsm_modulator #(.ORDER(ORD_FIRST)) i_dsm_modulator (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(load),
    .preset_i(preset), .din_i(din), .bit_o(bit1), .acc_o(acc1)
  );

  dsm_modulator #(.ORDER(ORD_SECOND)) i_dsm_modulator_o2 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(load),
    .preset_i(preset), .din_i(din), .bit_o(bit2), .acc_o(acc2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clip(int x);
    if (x > A_MAX) return A_MAX;
    if (x < A_MIN) return A_MIN;
    return x;
  endfunction

  function automatic int lvl(int w);
    return (w >= 0) ? FS : -FS;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic l, input int d, input int p);
    int y1, y2, vn;
    @(negedge clk);
    en = e; load = l; din = 16'(d); preset = 19'(p);
    @(posedge clk);
    #1;
    if (l) begin
      m1_w = p; m2_v = 0; m2_w = p;
    end else if (e) begin
      y1 = lvl(m1_w);
      m1_w = clip(m1_w + d - y1);
      y2 = lvl(m2_w);
      vn = clip(m2_v + d - y2);
      m2_w = clip(m2_w + vn - y2);
      m2_v = vn;
    end
    en = 0; load = 0;
  endtask

  task automatic cmp_models(string req);
    check({req, " order1 acc"}, int'(acc1), m1_w);
    check({req, " order1 bit"}, int'(bit1), (m1_w >= 0) ? 1 : 0);
    check({req, " order2 acc"}, int'(acc2), m2_w);
    check({req, " order2 bit"}, int'(bit2), (m2_w >= 0) ? 1 : 0);
  endtask

  task automatic t_reset();
    rst_n = 0; en = 0; load = 0; din = '0; preset = '0;
    m1_w = 0; m2_v = 0; m2_w = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 acc in reset", int'(acc1), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 order1 acc", int'(acc1), 0);
    check("R1 order1 bit", int'(bit1), 1);
    check("R1 order2 acc", int'(acc2), 0);
    check("R1 order2 bit", int'(bit2), 1);
  endtask

  task automatic t_sequence();
    step(0, 1, 0, 1638);
    check("R6 preset acc", int'(acc1), 1638);
    check("R2 preset bit", int'(bit1), 1);
    step(1, 0, 5461, 0);
    check("R6 step1 acc", int'(acc1), -9285);
    check("R2 step1 bit", int'(bit1), 0);
    step(1, 0, 5461, 0);
    check("R6 step2 acc", int'(acc1), 12560);
    check("R6 step2 bit", int'(bit1), 1);
    step(1, 0, 5461, 0);
    check("R6 step3 acc", int'(acc1), 1637);
    check("R3 step3 bit", int'(bit1), 1);
    cmp_models("R7 sequence");
  endtask

  task automatic t_hold();
    int a1, a2, b1, b2;
    a1 = acc1; a2 = acc2; b1 = bit1; b2 = bit2;
    for (int i = 0; i < 4; i++) begin
      step(0, 0, (i * 7000) - 12000, 0);
      check("R5 order1 acc", int'(acc1), a1);
      check("R5 order1 bit", int'(bit1), b1);
      check("R5 order2 acc", int'(acc2), a2);
      check("R5 order2 bit", int'(bit2), b2);
    end
  endtask

  task automatic t_load();
    step(1, 1, 9000, -700);
    check("R4 order1 acc", int'(acc1), -700);
    check("R4 order2 acc", int'(acc2), -700);
    check("R2 neg bit", int'(bit2), 0);
    step(1, 0, 0, 0);
    // inner accumulator was zeroed: v' = 0 + 0 + FS, w' = -700 + FS + FS
    check("R4 order2 inner zero", int'(acc2), -700 + 2 * FS);
    check("R10 order1 view", int'(acc1), -700 + FS);
    cmp_models("R4 follow");
  endtask

  task automatic t_saturate();
    step(0, 1, 0, A_MAX);
    step(1, 0, 32767, 0);
    check("R8 order1 upper", int'(acc1), A_MAX);
    check("R8 order1 upper bit", int'(bit1), 1);
    step(0, 1, 0, A_MIN);
    step(1, 0, -32768, 0);
    check("R8 order1 lower", int'(acc1), A_MIN);
    check("R8 order1 lower bit", int'(bit1), 0);
    cmp_models("R8 order2");
  endtask

  task automatic t_random();
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    step(0, 1, 0, 0);
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((i % 5) != 4, 0, int'(lfsr[13:0]) - 8192, 0);
      cmp_models("R7 R3 random");
    end
  endtask

  task automatic t_mean(input int u);
    int s1, s2, e1, e2;
    s1 = 0; s2 = 0;
    step(0, 1, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      step(1, 0, u, 0);
      s1 += bit1 ? 1 : -1;
      s2 += bit2 ? 1 : -1;
    end
    e1 = s1 - (4000 * u) / FS;
    e2 = s2 - (4000 * u) / FS;
    check("R9 order1 mean in bound", (e1 <= 4 && e1 >= -4) ? 1 : 0, 1);
    check("R9 order2 mean in bound", (e2 <= 8 && e2 >= -8) ? 1 : 0, 1);
    if (!(e1 <= 4 && e1 >= -4)) $display("  R9 order1 error %0d", e1);
    if (!(e2 <= 8 && e2 >= -8)) $display("  R9 order2 error %0d", e2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequence();
    t_hold();
    t_load();
    t_saturate();
    t_random();
    t_mean(6144);
    t_mean(-4096);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule